// File: doc/BRIEF.md
# Sensorless Motor Start-up Sequencer

This block takes a three-phase brushless motor without position sensors from standstill to closed-loop running. Once the power-good input is high and no stop request is present, it enters a fixed schedule. First it holds the commutation index still so that the rotor settles to a known position. Next it steps the index in open loop, and the step period shrinks after every step, so the commutation rate climbs steadily. Last it hands step timing to an external pulse, which a back-EMF-locked loop elsewhere on the chip generates.

The hold length, the open-loop ramp length, the starting and floor step periods and the per-step period reduction are all configuration inputs. A direction input chooses whether each step counts the commutation index up or down, modulo six. Dropping power-good or raising the stop request (brake or fault) returns the block to idle on the next edge. Start-up then begins again from the hold phase as soon as the condition clears.

Top module: `motor_startup_seq`

## Requirements
- R1: While `rst` is high, `mode` reads 0 (idle) and `comm_state` reads 0 at the next rising edge, whatever the other inputs are.
- R2: If `pwr_good` is low or `stop_req` is high at a rising edge, then after that edge `mode` is 0 and `comm_state` is 0. From idle, an edge with `pwr_good` high and `stop_req` low moves `mode` to 1 (align).
- R3: In align (`mode` = 1) `comm_state` is 0. Align lasts `cfg_align_len` clock cycles, with a value of 0 treated as 1, and is followed by ramp (`mode` = 2).
- R4: Ramp lasts `cfg_ramp_len` clock cycles, with 0 treated as 1, and is followed by run (`mode` = 3). The only way out of run is through R2.
- R5: In ramp, the first step comes on the `cfg_per_max`-th ramp cycle, with 0 treated as 1. After each step the period becomes the previous period minus `cfg_per_dec`. A step that falls on the last ramp cycle still takes effect.
- R6: In ramp, the period never drops below `cfg_per_min`. A reduction that would take it under `cfg_per_min` sets the period to `cfg_per_min`.
- R7: In run, `comm_state` changes by exactly one step at each edge where `run_step` is high, and it holds at every other edge.
- R8: At a step, `dir` = 0 moves `comm_state` from k to k+1, with 5 wrapping to 0. `dir` = 1 moves it from k to k-1, with 0 wrapping to 5. `dir` is sampled at each step.
- R9: `comm_state` always lies in the range 0 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply is valid; low forces idle |
| stop_req | input | 1 | Brake or fault request; high forces idle |
| dir | input | 1 | 0 counts steps up, 1 counts steps down |
| run_step | input | 1 | Single-cycle step pulse used in run mode |
| cfg_align_len | input | TMR_W | Align duration in cycles |
| cfg_ramp_len | input | TMR_W | Ramp duration in cycles |
| cfg_per_max | input | PER_W | First step period in ramp |
| cfg_per_dec | input | PER_W | Period reduction after each ramp step |
| cfg_per_min | input | PER_W | Floor on the ramp step period |
| mode | output | 2 | 0 idle, 1 align, 2 ramp, 3 run |
| comm_state | output | 3 | Commutation index 0..5 |

## Verification
Any fault in the phase timer shows up as a `mode` change one or more cycles away from the expected edge. The bench compares `mode` every cycle against a cycle model built from the requirements, so such a fault is caught on the first wrong edge. A fault in the ramp period register appears as a misplaced step on `comm_state`. That shows up within one step period, and a wrong floor shows up once the period reaches `cfg_per_min`. A wrong step direction or wrap shows up at the next step taken from index 0 or 5.

// File: rtl/motor_seq_pkg.sv
package motor_seq_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_ALIGN = 2'd1,
    MODE_RAMP  = 2'd2,
    MODE_RUN   = 2'd3
  } seq_mode_t;

  localparam int unsigned NUM_STEPS = 6;
  localparam int unsigned STEP_W    = 3;

  // Advance a commutation index by one, wrapping modulo NUM_STEPS.
  function automatic logic [STEP_W-1:0] step_adv(input logic [STEP_W-1:0] s,
                                                 input logic rev);
    logic [STEP_W-1:0] r;
    if (rev) begin
      r = (s == '0) ? STEP_W'(NUM_STEPS - 1) : s - 1'b1;
    end else begin
      r = (s >= STEP_W'(NUM_STEPS - 1)) ? '0 : s + 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/seq_phase_ctrl.sv
module seq_phase_ctrl
  import motor_seq_pkg::*;
#(
  parameter int unsigned TMR_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt,
  input  logic [TMR_W-1:0] align_len,
  input  logic [TMR_W-1:0] ramp_len,
  output seq_mode_t        mode_q
);

  logic [TMR_W-1:0] tmr_q;
  logic [TMR_W:0]   tmr_inc;
  logic [TMR_W:0]   align_eff;
  logic [TMR_W:0]   ramp_eff;
  logic             align_done;
  logic             ramp_done;

  assign tmr_inc    = {1'b0, tmr_q} + 1'b1;
  assign align_eff  = (align_len == '0) ? (TMR_W+1)'(1) : {1'b0, align_len};
  assign ramp_eff   = (ramp_len  == '0) ? (TMR_W+1)'(1) : {1'b0, ramp_len};
  assign align_done = (tmr_inc >= align_eff);
  assign ramp_done  = (tmr_inc >= ramp_eff);

  always_ff @(posedge clk) begin
    if (rst || halt) begin
      mode_q <= MODE_IDLE;
      tmr_q  <= '0;
    end else begin
      unique case (mode_q)
        MODE_IDLE: begin
          mode_q <= MODE_ALIGN;
          tmr_q  <= '0;
        end
        MODE_ALIGN: begin
          if (align_done) begin
            mode_q <= MODE_RAMP;
            tmr_q  <= '0;
          end else begin
            tmr_q  <= tmr_inc[TMR_W-1:0];
          end
        end
        MODE_RAMP: begin
          if (ramp_done) begin
            mode_q <= MODE_RUN;
            tmr_q  <= '0;
          end else begin
            tmr_q  <= tmr_inc[TMR_W-1:0];
          end
        end
        default: begin
          mode_q <= MODE_RUN;
          tmr_q  <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/ramp_rate_gen.sv
module ramp_rate_gen
  import motor_seq_pkg::*;
#(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  seq_mode_t        mode,
  input  logic [PER_W-1:0] per_max,
  input  logic [PER_W-1:0] per_dec,
  input  logic [PER_W-1:0] per_min,
  output logic             ramp_tick
);

  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] per_q;
  logic [PER_W:0]   per_eff;
  logic [PER_W:0]   cnt_inc;
  logic [PER_W:0]   floor_sum;
  logic [PER_W-1:0] per_next;

  assign per_eff   = (per_q == '0) ? (PER_W+1)'(1) : {1'b0, per_q};
  assign cnt_inc   = {1'b0, cnt_q} + 1'b1;
  assign ramp_tick = (mode == MODE_RAMP) && (cnt_inc >= per_eff);

  // Shrink the period by the decrement, but clamp at the floor.
  assign floor_sum = {1'b0, per_min} + {1'b0, per_dec};
  assign per_next  = ({1'b0, per_q} >= floor_sum) ? (per_q - per_dec) : per_min;

  always_ff @(posedge clk) begin
    if (rst || (mode != MODE_RAMP)) begin
      cnt_q <= '0;
      per_q <= per_max;
    end else if (ramp_tick) begin
      cnt_q <= '0;
      per_q <= per_next;
    end else begin
      cnt_q <= cnt_inc[PER_W-1:0];
    end
  end

endmodule

// File: rtl/comm_step_ctr.sv
module comm_step_ctr
  import motor_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              halt,
  input  seq_mode_t         mode,
  input  logic              ramp_tick,
  input  logic              run_step,
  input  logic              dir,
  output logic [STEP_W-1:0] state_q
);

  logic advance;

  always_comb begin
    unique case (mode)
      MODE_RAMP: advance = ramp_tick;
      MODE_RUN:  advance = run_step;
      default:   advance = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || halt || (mode == MODE_IDLE) || (mode == MODE_ALIGN)) begin
      state_q <= '0;
    end else if (advance) begin
      state_q <= step_adv(state_q, dir);
    end
  end

endmodule

// File: rtl/motor_startup_seq.sv
module motor_startup_seq
  import motor_seq_pkg::*;
#(
  parameter int unsigned TMR_W = 20,
  parameter int unsigned PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_good,
  input  logic             stop_req,
  input  logic             dir,
  input  logic             run_step,
  input  logic [TMR_W-1:0] cfg_align_len,
  input  logic [TMR_W-1:0] cfg_ramp_len,
  input  logic [PER_W-1:0] cfg_per_max,
  input  logic [PER_W-1:0] cfg_per_dec,
  input  logic [PER_W-1:0] cfg_per_min,
  output logic [1:0]       mode,
  output logic [2:0]       comm_state
);

  seq_mode_t         mode_q;
  logic              halt;
  logic              ramp_tick;
  logic [STEP_W-1:0] state_q;

  assign halt = !pwr_good || stop_req;

  seq_phase_ctrl #(.TMR_W(TMR_W)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .halt      (halt),
    .align_len (cfg_align_len),
    .ramp_len  (cfg_ramp_len),
    .mode_q    (mode_q)
  );

  ramp_rate_gen #(.PER_W(PER_W)) u_ramp (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode_q),
    .per_max   (cfg_per_max),
    .per_dec   (cfg_per_dec),
    .per_min   (cfg_per_min),
    .ramp_tick (ramp_tick)
  );

  comm_step_ctr u_comm (
    .clk       (clk),
    .rst       (rst),
    .halt      (halt),
    .mode      (mode_q),
    .ramp_tick (ramp_tick),
    .run_step  (run_step),
    .dir       (dir),
    .state_q   (state_q)
  );

  assign mode       = mode_q;
  assign comm_state = state_q;

endmodule

// File: rtl/motor_startup_seq_chk.sv
module motor_startup_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       pwr_good,
  input logic       stop_req,
  input logic       dir,
  input logic       run_step,
  input logic [1:0] mode,
  input logic [2:0] comm_state
);

  logic go;
  assign go = pwr_good && !stop_req;

  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (rst)
    comm_state < 3'd6); // R9

  AST_HALT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !go |=> (mode == 2'd0) && (comm_state == 3'd0)); // R2

  AST_IDLE_START: assert property (@(posedge clk) disable iff (rst)
    (go && mode == 2'd0) |=> mode == 2'd1); // R2

  AST_ALIGN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1) |-> comm_state == 3'd0); // R3

  AST_ALIGN_NEXT: assert property (@(posedge clk) disable iff (rst)
    (go && mode == 2'd1) |=> (mode == 2'd1) || (mode == 2'd2)); // R3

  AST_RAMP_NEXT: assert property (@(posedge clk) disable iff (rst)
    (go && mode == 2'd2) |=> (mode == 2'd2) || (mode == 2'd3)); // R4

  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (go && mode == 2'd3 && !run_step) |=> (mode == 2'd3) && $stable(comm_state)); // R7

  AST_RUN_FWD: assert property (@(posedge clk) disable iff (rst)
    (go && mode == 2'd3 && run_step && !dir) |=>
      comm_state == (($past(comm_state) == 3'd5) ? 3'd0 : $past(comm_state) + 3'd1)); // R8

  AST_RUN_REV: assert property (@(posedge clk) disable iff (rst)
    (go && mode == 2'd3 && run_step && dir) |=>
      comm_state == (($past(comm_state) == 3'd0) ? 3'd5 : $past(comm_state) - 3'd1)); // R8

endmodule

bind motor_startup_seq motor_startup_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .pwr_good   (pwr_good),
  .stop_req   (stop_req),
  .dir        (dir),
  .run_step   (run_step),
  .mode       (mode),
  .comm_state (comm_state)
);

// File: tb/motor_startup_seq_test.sv
module motor_startup_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int TMR_W = 20;
  localparam int PER_W = 16;
  localparam int NVEC = 5;
  // align, ramp, per_max, per_dec, per_min, dir
  localparam int VEC [0:NVEC-1][0:5] = '{
    '{4, 30, 6, 1, 2, 0},
    '{1, 25, 4, 0, 1, 1},
    '{0, 12, 3, 5, 2, 0},
    '{6,  1, 2, 1, 1, 1},
    '{3, 40, 0, 1, 1, 0}
  };

  logic clk = 1'b0;
  logic rst, pwr_good, stop_req, dir, run_step;
  logic [TMR_W-1:0] cfg_align_len, cfg_ramp_len;
  logic [PER_W-1:0] cfg_per_max, cfg_per_dec, cfg_per_min;
  logic [1:0] mode;
  logic [2:0] comm_state;

  int n_cmp = 0;
  int n_bad = 0;

  // Reference model state
  int m_mode, m_comm, m_tmr, m_cnt, m_per;

  always #(CLK_PERIOD/2) clk = ~clk;

  motor_startup_seq #(.TMR_W(TMR_W), .PER_W(PER_W)) uut (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .stop_req(stop_req),
    .dir(dir), .run_step(run_step),
    .cfg_align_len(cfg_align_len), .cfg_ramp_len(cfg_ramp_len),
    .cfg_per_max(cfg_per_max), .cfg_per_dec(cfg_per_dec), .cfg_per_min(cfg_per_min),
    .mode(mode), .comm_state(comm_state)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int adv(input int s, input logic rv);
    if (rv) return (s == 0) ? 5 : s - 1;
    return (s == 5) ? 0 : s + 1;
  endfunction

  function automatic int atleast1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // One model edge built from the requirements
  task automatic model_edge(input logic pg, input logic st, input logic dr, input logic rs);
    int pm, pc, pt, pcnt, pper;
    logic stp;
    pm = m_mode; pc = m_comm; pt = m_tmr; pcnt = m_cnt; pper = m_per;
    stp = (pm == 2) && (pcnt + 1 >= atleast1(pper));
    if (pm != 2) begin
      m_cnt = 0; m_per = int'(cfg_per_max);
    end else if (stp) begin
      m_cnt = 0;
      m_per = (pper - int'(cfg_per_dec) >= int'(cfg_per_min)) ? pper - int'(cfg_per_dec)
                                                             : int'(cfg_per_min);
    end else begin
      m_cnt = pcnt + 1;
    end
    if (!pg || st) begin
      m_mode = 0; m_comm = 0; m_tmr = 0;
    end else begin
      case (pm)
        0: begin m_mode = 1; m_tmr = 0; m_comm = 0; end
        1: begin
          m_comm = 0;
          if (pt + 1 >= atleast1(int'(cfg_align_len))) begin m_mode = 2; m_tmr = 0; end
          else m_tmr = pt + 1;
        end
        2: begin
          if (stp) m_comm = adv(pc, dr);
          if (pt + 1 >= atleast1(int'(cfg_ramp_len))) begin m_mode = 3; m_tmr = 0; end
          else m_tmr = pt + 1;
        end
        default: if (rs) m_comm = adv(pc, dr);
      endcase
    end
  endtask

  task automatic tick(input logic pg, input logic st, input logic dr, input logic rs);
    @(negedge clk);
    pwr_good = pg; stop_req = st; dir = dr; run_step = rs;
    @(posedge clk);
    model_edge(pg, st, dr, rs);
    #1;
    case (m_mode)
      0: check("R2 mode", int'(mode), m_mode);
      1: check("R3 mode", int'(mode), m_mode);
      2: check("R4 mode", int'(mode), m_mode);
      default: check("R4 mode", int'(mode), m_mode);
    endcase
    case (m_mode)
      2: check("R5/R6 comm_state", int'(comm_state), m_comm);
      3: check("R7/R8 comm_state", int'(comm_state), m_comm);
      default: check("R3 comm_state", int'(comm_state), m_comm);
    endcase
    check("R9 range", int'(comm_state < 3'd6), 1);
  endtask

  task automatic load_cfg(input int idx);
    cfg_align_len = TMR_W'(VEC[idx][0]);
    cfg_ramp_len  = TMR_W'(VEC[idx][1]);
    cfg_per_max   = PER_W'(VEC[idx][2]);
    cfg_per_dec   = PER_W'(VEC[idx][3]);
    cfg_per_min   = PER_W'(VEC[idx][4]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; pwr_good = 1'b1; stop_req = 1'b0; dir = 1'b0; run_step = 1'b0;
    load_cfg(0);
    m_mode = 0; m_comm = 0; m_tmr = 0; m_cnt = 0; m_per = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset mode", int'(mode), 0);
    check("R1 reset comm_state", int'(comm_state), 0);
    @(negedge clk);
    rst = 1'b0; pwr_good = 1'b0;
    @(posedge clk);
    #1;
    m_cnt = 0; m_per = int'(cfg_per_max);

    // Vector table: full start-up for each configuration
    for (int v = 0; v < NVEC; v++) begin
      int n_al, n_rp;
      logic dv;
      load_cfg(v);
      dv = VEC[v][5] != 0;
      tick(1'b0, 1'b0, dv, 1'b0);
      n_al = 0; n_rp = 0;
      for (int c = 0; c < VEC[v][0] + VEC[v][1] + 40; c++) begin
        tick(1'b1, 1'b0, dv, (c % 4) == 1);
        if (mode == 2'd1) n_al++;
        if (mode == 2'd2) n_rp++;
      end
      check("R3 align cycles", n_al, atleast1(VEC[v][0]));
      check("R4 ramp cycles", n_rp, atleast1(VEC[v][1]));
      check("R4 ends in run", int'(mode), 3);
    end

    // Directed: stop request during ramp, then release restarts at align
    load_cfg(0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    for (int c = 0; c < 15; c++) tick(1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b1, 1'b1, 1'b0, 1'b0);
    check("R2 stop to idle", int'(mode), 0);
    check("R2 stop clears comm_state", int'(comm_state), 0);
    tick(1'b1, 1'b1, 1'b0, 1'b1);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    check("R2 restart at align", int'(mode), 1);

    // Reach run, then hold without pulses
    for (int c = 0; c < 40; c++) tick(1'b1, 1'b0, 1'b0, 1'b0);
    begin
      logic [2:0] held;
      held = comm_state;
      for (int c = 0; c < 10; c++) tick(1'b1, 1'b0, c[0], 1'b0);
      check("R7 no step holds comm_state", int'(comm_state), int'(held));
    end

    // Run: wrap in both directions
    for (int c = 0; c < 8; c++) tick(1'b1, 1'b0, 1'b0, 1'b1);
    for (int c = 0; c < 9; c++) tick(1'b1, 1'b0, 1'b1, 1'b1);
    for (int c = 0; c < 6; c++) tick(1'b1, 1'b0, c[1], 1'b1);

    // Power loss in run
    tick(1'b0, 1'b0, 1'b0, 1'b1);
    check("R2 power loss to idle", int'(mode), 0);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    check("R2 power return at align", int'(mode), 1);

    // Reset during operation
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 reset in operation", int'(mode), 0);
    @(negedge clk);
    rst = 1'b0;
    m_mode = 0; m_comm = 0; m_tmr = 0; m_cnt = 0; m_per = int'(cfg_per_max);
    tick(1'b1, 1'b0, 1'b0, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule